// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flag-Carrying Receive Queue

This block takes an asynchronous serial line and rebuilds characters of five to nine data bits from it. An optional parity bit may follow the data. The line is first passed through a synchroniser. An external oversampling tick (OVERSAMPLE ticks per bit) paces a frame engine. The engine checks a start bit at its centre, samples each later bit at its centre, and closes the character on the first stop bit.

Each closed character enters a two-entry queue together with its own frame, parity and overflow flags. A small read port shows two registers, a status register and a data register. Both describe the entry at the head of the queue. Reading the data register pops that entry, so software reads status and the ninth bit first, then the low byte. A frame that arrives while the queue is full is thrown away, and the newest stored entry is marked as overflowed. A line held low after a failed stop bit is treated as a break: no new start is looked for until the line is high again.

Top module: `rxq_uart`

## Requirements
- R1: After reset, irq_o is 0 and both registers read 0. While the queue is empty, both registers read 0.
- R2: A low level is accepted as a start bit only if the line is still low at the half-bit sample. A shorter low pulse produces no character.
- R3: Data bits are taken least significant bit first. The number of bits is set by cfg_bits_i: a value from 5 to 9 gives that many bits, and any other value gives 8. Data register bits at or above the character size read 0.
- R4: For 9-bit characters, the ninth data bit appears at status bit 0. For shorter characters, that bit reads 0.
- R5: cfg_par_i 2'b10 selects even parity and 2'b11 selects odd parity. Either value 2'b0x means no parity bit. A parity mismatch sets status bit 2 of that entry.
- R6: A stop bit sampled low sets status bit 4 (frame error), and the character is still stored.
- R7: Only the first stop bit is sampled. A new start bit may follow it directly, and both characters are received.
- R8: Status bit 7 and irq_o are 1 exactly while the queue holds at least one entry.
- R9: A read with rd_addr_i = 1 (data) pops the head entry, and its effect shows one cycle later. A read with rd_addr_i = 0 (status) leaves the queue unchanged.
- R10: A character that completes while both entries are in use is dropped. Status bit 3 (overflow) is then set on the newest stored entry.
- R11: Each entry keeps its own error flags. After a pop, the status flags show the next entry's flags, not the previous one's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversampling tick, OVERSAMPLE pulses per bit |
| cfg_bits_i | input | 4 | Character size, 5 to 9 |
| cfg_par_i | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | 0 status, 1 data |
| rd_data_o | output | 8 | Read data for rd_addr_i, combinational |
| irq_o | output | 1 | Receive-complete indication |

## Verification
A character enters the queue on the tick that samples the middle of its first stop bit. That point comes two synchroniser stages plus one engine register after the line value it samples, well before the stop bit ends. Both registers are combinational views of the queue head, so status and data are valid in the same cycle as the push. A pop shows one clock edge after the read strobe. The bench therefore reads only after the whole stop-bit period has been driven, samples the read data 1 ns after the falling edge that applies the read, and checks the next entry in the following cycle.

// File: rtl/rxq_pkg.sv
// Package: shared types and register bit positions for the serial receiver.
// Assumes at most nine data bits per character.
package rxq_pkg;
    localparam int unsigned MAX_BITS = 9;

    // One queue entry: character plus the flags that belong to it.
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ferr;
        logic                perr;
        logic                ovf;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

    // Status register bit positions (software decodes these).
    localparam int unsigned SB_DONE  = 7;
    localparam int unsigned SB_FERR  = 4;
    localparam int unsigned SB_OVF   = 3;
    localparam int unsigned SB_PERR  = 2;
    localparam int unsigned SB_NINTH = 0;
endpackage

// File: rtl/rxq_sync.sv
// Module: multi-stage synchroniser for the asynchronous line.
// Assumes STAGES >= 2. Resets to the idle (high) level so that no false
// start bit is seen out of reset.
module rxq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rxq_frame.sv
// Module: frame engine. Checks the start bit at half a bit, samples data,
// the optional parity bit and the first stop bit at bit centres, and
// pushes one entry per frame. Assumes a synchronised line and a tick of
// OVERSAMPLE pulses per bit. Size and parity are latched when a start is
// seen. After a low stop bit the engine waits for the line to go high.
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic [3:0] cfg_bits_i,
    input  logic [1:0] cfg_par_i,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam int unsigned CW   = $clog2(OVERSAMPLE);
    localparam int unsigned HALF = OVERSAMPLE / 2;

    rx_state_e           state;
    logic [CW-1:0]       tcnt;
    logic [3:0]          bidx;
    logic [3:0]          nbits_q;
    logic                par_en_q;
    logic                par_odd_q;
    logic                par_bit;
    logic [MAX_BITS-1:0] shreg;

    // Map the size setting to a bit count; unsupported codes act as 8.
    function automatic logic [3:0] size_of(input logic [3:0] code);
        return (code >= 4'd5 && code <= 4'd9) ? code : 4'd8;
    endfunction

    // Main sequencer: one step per oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            nbits_q   <= 4'd8;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
            par_bit   <= 1'b0;
            shreg     <= '0;
            push_o    <= 1'b0;
            entry_o   <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_i) begin
                            state     <= ST_START;
                            tcnt      <= '0;
                            nbits_q   <= size_of(cfg_bits_i);
                            par_en_q  <= cfg_par_i[1];
                            par_odd_q <= cfg_par_i[0];
                        end
                    end
                    ST_START: begin
                        if (tcnt == CW'(HALF - 1)) begin
                            tcnt <= '0;
                            if (!rx_i) begin
                                state <= ST_DATA;
                                bidx  <= '0;
                                shreg <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (tcnt == CW'(OVERSAMPLE - 1)) begin
                            tcnt        <= '0;
                            shreg[bidx] <= rx_i;
                            if (bidx == nbits_q - 4'd1) begin
                                state <= par_en_q ? ST_PAR : ST_STOP;
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end else begin
                            tcnt <= tcnt + CW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (tcnt == CW'(OVERSAMPLE - 1)) begin
                            tcnt    <= '0;
                            par_bit <= rx_i;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == CW'(OVERSAMPLE - 1)) begin
                            tcnt          <= '0;
                            push_o        <= 1'b1;
                            entry_o.data  <= shreg;
                            entry_o.ferr  <= !rx_i;
                            entry_o.perr  <= par_en_q & (^shreg ^ par_bit ^ par_odd_q);
                            entry_o.ovf   <= 1'b0;
                            state         <= rx_i ? ST_IDLE : ST_BREAK;
                        end else begin
                            tcnt <= tcnt + CW'(1);
                        end
                    end
                    ST_BREAK: begin
                        if (rx_i) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxq_fifo.sv
// Module: small receive queue of flagged entries. A push into a full queue
// without a simultaneous pop is dropped and marks the newest stored entry
// as overflowed. The head reads all-zero when empty.
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  rx_entry_t                    entry_i,
    input  logic                         pop_i,
    output rx_entry_t                    head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rx_entry_t       slots [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            empty;
    logic            full;
    logic            do_pop;
    logic            accept;
    logic            mark_ovf;
    logic [AW-1:0]   newest;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
    endfunction

    assign empty    = (count_o == '0);
    assign full     = (count_o == CW'(DEPTH));
    assign do_pop   = pop_i && !empty;
    assign accept   = push_i && (!full || do_pop);
    assign mark_ovf = push_i && full && !do_pop;
    assign newest   = ptr_dec(wr_ptr);

    // Per-slot storage: write on accept, set overflow on the newest entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (accept && wr_ptr == AW'(i)) begin
                slots[i] <= entry_i;
            end else if (mark_ovf && newest == AW'(i)) begin
                slots[i].ovf <= 1'b1;
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (accept) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
            case ({accept, do_pop})
                2'b10:   count_o <= count_o + CW'(1);
                2'b01:   count_o <= count_o - CW'(1);
                default: count_o <= count_o;
            endcase
        end
    end

    assign head_o = empty ? '0 : slots[rd_ptr];
endmodule

// File: rtl/rxq_uart.sv
// Module: top of the serial receiver. Chains the synchroniser, the frame
// engine and the queue, and shows a two-register read port: address 0 is
// status (flags and ninth bit of the head entry), address 1 is the low
// data byte. A data read pops. Assumes the tick is created outside.
module rxq_uart
    import rxq_pkg::*;
#(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned FIFO_DEPTH  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [3:0] cfg_bits_i,
    input  logic [1:0] cfg_par_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    localparam int unsigned QCW = $clog2(FIFO_DEPTH + 1);

    logic                rx_sync;
    logic                frm_push;
    rx_entry_t           frm_entry;
    rx_entry_t           head;
    logic [QCW-1:0]      fifo_count;
    logic                fifo_pop;
    logic                have_data;
    logic [7:0]          status;

    rxq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_sync)
    );

    rxq_frame #(.OVERSAMPLE(OVERSAMPLE)) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .rx_i       (rx_sync),
        .cfg_bits_i (cfg_bits_i),
        .cfg_par_i  (cfg_par_i),
        .push_o     (frm_push),
        .entry_o    (frm_entry)
    );

    assign fifo_pop = rd_en_i && rd_addr_i;

    rxq_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (frm_push),
        .entry_i (frm_entry),
        .pop_i   (fifo_pop),
        .head_o  (head),
        .count_o (fifo_count)
    );

    assign have_data = (fifo_count != '0);

    // Assemble the status view of the head entry.
    always_comb begin
        status           = '0;
        status[SB_DONE]  = have_data;
        status[SB_FERR]  = head.ferr;
        status[SB_OVF]   = head.ovf;
        status[SB_PERR]  = head.perr;
        status[SB_NINTH] = head.data[8];
    end

    assign rd_data_o = rd_addr_i ? head.data[7:0] : status;
    assign irq_o     = have_data;
endmodule

// File: rtl/rxq_chk.sv
// Module: assertion checker for rxq_uart, attached by bind below.
module rxq_chk
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq,
    input logic                       push,
    input rx_entry_t                  entry,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       rd_en,
    input logic                       rd_addr,
    input logic [3:0]                 cfg_bits,
    input logic [7:0]                 rd_data
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    // R1: an empty queue reads zero on either address
    a_r1_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rd_data == 8'h00));

    // R3: five-bit characters carry no upper bits
    a_r3_short_char_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cfg_bits == 4'd5) |-> (entry.data[8:5] == 4'b0000));

    // R8: the completion indication only rises after a frame push
    a_r8_irq_rise_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(push));

    // R9: a status read without a push leaves occupancy unchanged
    a_r9_status_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_addr && !push) |=> $stable(count));

    // R9: a data read of a non-empty queue without a push removes one entry
    a_r9_data_read_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr && count != '0 && !push) |=> (count == $past(count) - CW'(1)));

    // R10: occupancy never exceeds the queue depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

bind rxq_uart rxq_chk #(.DEPTH(FIFO_DEPTH)) i_rxq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq_o),
    .push     (frm_push),
    .entry    (frm_entry),
    .count    (fifo_count),
    .rd_en    (rd_en_i),
    .rd_addr  (rd_addr_i),
    .cfg_bits (cfg_bits_i),
    .rd_data  (rd_data_o)
);

// File: tb/test_rxq_uart.sv
module test_rxq_uart;
    localparam int OS      = 16;
    localparam int BIT_CLK = OS * 2;   // tick every second clock

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_par = 2'b00;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    rxq_uart #(.OVERSAMPLE(OS), .FIFO_DEPTH(2), .SYNC_STAGES(2)) i_rxq_uart (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
        .cfg_bits_i(cfg_bits), .cfg_par_i(cfg_par),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        rx = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    function automatic logic [8:0] mask_of(input logic [8:0] d, input int nb);
        return d & 9'((1 << nb) - 1);
    endfunction

    function automatic logic [7:0] exp_status(input logic [8:0] d, input int nb,
                                              input logic [1:0] pm, input bit bad_par,
                                              input bit bad_stop, input bit ovf);
        logic [8:0] m = mask_of(d, nb);
        return {1'b1, 2'b00, bad_stop, ovf, pm[1] & bad_par, 1'b0, m[8]};
    endfunction

    task automatic send_frame(input logic [8:0] d, input int nb, input logic [1:0] pm,
                              input bit bad_par, input bit bad_stop);
        logic [8:0] m = mask_of(d, nb);
        cfg_bits = 4'(nb);
        cfg_par  = pm;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(m[i]);
        if (pm[1]) send_bit((^m) ^ pm[0] ^ bad_par);
        send_bit(!bad_stop);
        if (bad_stop) send_bit(1'b1);
    endtask

    // One register read: apply at a falling edge, sample 1 ns later.
    task automatic read_reg(input logic a, output logic [7:0] v);
        rd_addr = a;
        rd_en   = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic expect_entry(input string tag, input logic [8:0] d, input int nb,
                                input logic [1:0] pm, input bit bp, input bit bs, input bit ovf);
        logic [7:0] s, v;
        logic [8:0] m = mask_of(d, nb);
        read_reg(1'b0, s);
        chk({tag, " status"}, {8'h0, s}, {8'h0, exp_status(d, nb, pm, bp, bs, ovf)});
        read_reg(1'b1, v);
        chk({tag, " data"}, {8'h0, v}, {8'h0, m[7:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1: reset state
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        read_reg(1'b0, v); chk("R1 status after reset", {8'h0, v}, 16'h0);
        read_reg(1'b1, v); chk("R1 data after reset", {8'h0, v}, 16'h0);

        // R3 R8: plain eight-bit character
        send_frame(9'h0A5, 8, 2'b00, 0, 0);
        chk("R8 irq with one entry", {15'h0, irq}, 16'h1);
        expect_entry("R3 8-bit", 9'h0A5, 8, 2'b00, 0, 0, 0);
        chk("R8 irq after last pop", {15'h0, irq}, 16'h0);

        // R3: five-bit character, upper bits zero
        send_frame(9'h1F7, 5, 2'b00, 0, 0);
        expect_entry("R3 5-bit upper zero", 9'h1F7, 5, 2'b00, 0, 0, 0);

        // R4: ninth bit in status
        send_frame(9'h155, 9, 2'b00, 0, 0);
        expect_entry("R4 ninth bit", 9'h155, 9, 2'b00, 0, 0, 0);

        // R5: parity even bad, odd good
        send_frame(9'h03C, 7, 2'b10, 1, 0);
        expect_entry("R5 even parity error", 9'h03C, 7, 2'b10, 1, 0, 0);
        send_frame(9'h0C3, 8, 2'b11, 0, 0);
        expect_entry("R5 odd parity clean", 9'h0C3, 8, 2'b11, 0, 0, 0);

        // R6: low stop bit
        send_frame(9'h05A, 8, 2'b00, 0, 1);
        expect_entry("R6 frame error", 9'h05A, 8, 2'b00, 0, 1, 0);

        // R2: short low glitch is rejected
        rx = 1'b0; repeat (6) @(negedge clk);
        rx = 1'b1; repeat (BIT_CLK * 12) @(negedge clk);
        chk("R2 glitch irq", {15'h0, irq}, 16'h0);
        read_reg(1'b0, v); chk("R2 glitch status", {8'h0, v}, 16'h0);

        // R7 R11 R9: back-to-back frames with distinct flags
        send_frame(9'h011, 8, 2'b10, 1, 0);
        send_frame(9'h0EE, 8, 2'b10, 0, 0);
        read_reg(1'b0, v);
        chk("R9 status read no pop", {8'h0, v}, {8'h0, exp_status(9'h011, 8, 2'b10, 1, 0, 0)});
        expect_entry("R7 first of pair", 9'h011, 8, 2'b10, 1, 0, 0);
        expect_entry("R11 flags of next entry", 9'h0EE, 8, 2'b10, 0, 0, 0);

        // R10: third frame overflows
        send_frame(9'h001, 8, 2'b00, 0, 0);
        send_frame(9'h002, 8, 2'b00, 0, 0);
        send_frame(9'h003, 8, 2'b00, 0, 0);
        expect_entry("R10 oldest entry", 9'h001, 8, 2'b00, 0, 0, 0);
        expect_entry("R10 overflow marked", 9'h002, 8, 2'b00, 0, 0, 1);
        chk("R10 dropped frame absent", {15'h0, irq}, 16'h0);

        // Random mix: R3 R5 R6 R11
        for (int it = 0; it < 40; it++) begin
            int          nf  = 1 + int'($urandom_range(1, 0));
            logic [8:0]  d0  = 9'($urandom);
            logic [8:0]  d1  = 9'($urandom);
            int          nb  = int'($urandom_range(9, 5));
            logic [1:0]  pm  = 2'($urandom);
            bit          bp0 = ($urandom_range(3, 0) == 0);
            bit          bs0 = ($urandom_range(4, 0) == 0);
            bit          bp1 = ($urandom_range(3, 0) == 0);
            send_frame(d0, nb, pm, bp0, bs0);
            if (nf == 2) send_frame(d1, nb, pm, bp1, 0);
            expect_entry("R11 random first", d0, nb, pm, bp0, bs0, 0);
            if (nf == 2) expect_entry("R3 random second", d1, nb, pm, bp1, 0, 0);
            chk("R8 random empty", {15'h0, irq}, 16'h0);
        end

        summary();
    end
endmodule